// File: doc/BRIEF.md
# Instruction Fetch Line Cache

A read-only, direct-mapped instruction cache between a 32-bit processor fetch port and a 64-bit memory bus. Each cacheable fetch is looked up in a 64-line store of 256-bit lines. A hit answers in the same cycle. A miss starts one refill. The refill is four 64-bit beats in wrapping order, and the first beat is the doubleword that holds the requested word. The beats collect in a single 256-bit staging buffer. That buffer also serves the processor while the refill is still running. The complete line is written into the store together with the fourth beat.

Fetches marked non-cacheable never touch the store. They go out unchanged on a separate 32-bit path. A write-snoop input invalidates any cached line whose address matches a write. A global invalidate input sweeps all valid bits, and cacheable fetches stall until the sweep is done.

Top module: `ifetch_line_cache`

## Requirements
- R1: A cacheable fetch whose line is valid with a matching tag raises `fetch_valid_o` in the same cycle as the request, with no wait cycle, and issues no memory request.
- R2: Address split: bits [10:5] select one of 64 lines, bits [4:2] select the 32-bit word within the line, and bits [31:11] are the tag. Two addresses with the same index and different tags displace each other.
- R3: On a miss with no refill running, `mem_req_o` rises with `mem_addr_o` equal to the fetch address with bits [2:0] cleared. Request and address are held until `mem_gnt_i`, and exactly one request is made per refill.
- R4: After the grant, the four beats that `mem_rvalid_i` marks carry doublewords in the order start, start+1, ... modulo 4, where start is bits [4:3] of `mem_addr_o`. In each beat the lower address is in bits [31:0]. The filled line is installed with the fourth beat, so that every word of it then hits.
- R5: The requested word is returned in the same cycle that its beat is on the bus.
- R6: A fetch of another word of the line under refill makes no new request. It is served in the cycle its beat arrives, or at once if the beat has already arrived.
- R7: A miss to a different line while a refill is running waits until that refill has finished. Then it starts its own refill, and no request is raised while beats are outstanding.
- R8: A non-cacheable fetch drives `unc_req_o` with `unc_addr_o` equal to the fetch address. It is answered with `unc_rdata_i` in the cycle `unc_rvalid_i` is high. It neither reads nor changes the line store and makes no memory request.
- R9: A snoop write whose index and tag match a valid line clears that line's valid bit at the next clock edge. A snoop with the same index and a different tag changes nothing.
- R10: A snoop write that matches the line under refill, seen before the fourth beat, prevents that line from being installed.
- R11: A pulse on `flush_i` clears every valid bit within 64 cycles. Cacheable fetches are not served from the `flush_i` cycle until the sweep ends.
- R12: After reset no line is valid and `fetch_valid_o`, `mem_req_o` and `unc_req_o` are low while no fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, held until served |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_cacheable_i | input | 1 | Fetch may be cached |
| fetch_valid_o | output | 1 | Fetch data valid this cycle |
| fetch_data_o | output | 32 | Fetched instruction word |
| mem_req_o | output | 1 | Line refill request |
| mem_addr_o | output | 32 | Critical doubleword address of the refill |
| mem_gnt_i | input | 1 | Refill request accepted |
| mem_rvalid_i | input | 1 | Refill beat valid |
| mem_rdata_i | input | 64 | Refill beat data |
| unc_req_o | output | 1 | Non-cacheable access request |
| unc_addr_o | output | 32 | Non-cacheable access address |
| unc_rvalid_i | input | 1 | Non-cacheable data valid |
| unc_rdata_i | input | 32 | Non-cacheable data |
| snoop_wr_i | input | 1 | Write to a cacheable page observed |
| snoop_addr_i | input | 32 | Address of the observed write |
| flush_i | input | 1 | Invalidate all lines |

## Verification
The assertions watch, on every cycle, the properties that involve only a few signals at once. A valid hit is served at once. A pending refill request holds steady until granted. No buffer slot is written twice per refill. A matching snoop clears its line at the next edge. The sweep ends within its bound. Nothing cacheable is served while invalidation runs, and a poisoned refill is never installed.

Only the bench scenarios can show that the right data lands in the right word. That covers the wrap order for every start beat and the critical word coming back with the first beat. It also covers service of later words from the staging buffer, stale contents surviving behind an uncached read, and every line missing after a flush.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_REQ   = 2'd1,
    FILL_BEATS = 2'd2
  } fill_state_e;
endpackage

// File: rtl/ilc_tag_store.sv
module ilc_tag_store #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int TAG_W     = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  input  logic             snoop_i,
  input  logic [IDX_W-1:0] snoop_idx_i,
  input  logic [TAG_W-1:0] snoop_tag_i,
  input  logic             inst_i,
  input  logic [IDX_W-1:0] inst_idx_i,
  input  logic [TAG_W-1:0] inst_tag_i,
  input  logic             flush_i,
  output logic             flushing_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic                 flushing_q;
  logic [IDX_W-1:0]     sweep_q;
  logic                 snoop_hit;

  assign rd_hit_o   = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign snoop_hit  = snoop_i && valid_q[snoop_idx_i] && (tag_q[snoop_idx_i] == snoop_tag_i);
  assign flushing_o = flushing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      flushing_q <= 1'b0;
      sweep_q    <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else begin
      if (inst_i) begin
        valid_q[inst_idx_i] <= 1'b1;
        tag_q[inst_idx_i]   <= inst_tag_i;
      end
      // clears override a same-cycle install
      if (snoop_hit) valid_q[snoop_idx_i] <= 1'b0;
      if (flushing_q) begin
        valid_q[sweep_q] <= 1'b0;
        sweep_q          <= sweep_q + 1'b1;
        if (sweep_q == LAST_IDX) flushing_q <= 1'b0;
      end
      if (flush_i) begin
        flushing_q <= 1'b1;
        sweep_q    <= '0;
      end
    end
  end

  // sweep-length monitor for the assertion
  logic [IDX_W+1:0] sweep_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sweep_len_q <= '0;
    else if (flushing_q) sweep_len_q <= sweep_len_q + 1'b1;
    else                 sweep_len_q <= '0;
  end

  a_r9_snoop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit |=> !valid_q[$past(snoop_idx_i)]);

  a_r11_sweep_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_len_q <= (IDX_W+2)'(NUM_LINES));
endmodule

// File: rtl/ilc_data_store.sv
module ilc_data_store #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int LINE_W    = 256
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o
);
  logic [LINE_W-1:0] mem_q [NUM_LINES];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_idx_i] <= wr_line_i;
  end

  assign rd_line_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ilc_line_buffer.sv
module ilc_line_buffer #(
  parameter int LA_W   = 27,
  parameter int BUS_W  = 64,
  parameter int BEATS  = 4,
  parameter int BEAT_W = $clog2(BEATS),
  parameter int LINE_W = BUS_W * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              start_i,
  input  logic [LA_W-1:0]   start_line_i,
  input  logic [BEAT_W-1:0] start_beat_i,
  input  logic              beat_i,
  input  logic [BUS_W-1:0]  beat_data_i,
  input  logic [LA_W-1:0]   look_line_i,
  input  logic [BEAT_W-1:0] look_beat_i,
  output logic              hit_o,
  output logic [BUS_W-1:0]  hit_dword_o,
  output logic [LA_W-1:0]   line_o,
  output logic              last_o,
  output logic [LINE_W-1:0] fill_line_o
);
  logic [LA_W-1:0]   line_q;
  logic [BEATS-1:0]  vld_q;
  logic [BEAT_W-1:0] ptr_q;
  logic [BUS_W-1:0]  dw_q [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      vld_q  <= '0;
      ptr_q  <= '0;
    end else if (start_i) begin
      line_q <= start_line_i;
      vld_q  <= '0;
      ptr_q  <= start_beat_i;
    end else if (beat_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1;   // wraps modulo BEATS
    end
  end

  always_ff @(posedge clk_i) begin
    if (beat_i) dw_q[ptr_q] <= beat_data_i;
  end

  assign line_o      = line_q;
  assign hit_o       = active_i && (line_q == look_line_i) &&
                       (vld_q[look_beat_i] || (beat_i && ptr_q == look_beat_i));
  assign hit_dword_o = vld_q[look_beat_i] ? dw_q[look_beat_i] : beat_data_i;
  assign last_o      = beat_i && ($countones(vld_q) == BEATS - 1);

  for (genvar b = 0; b < BEATS; b++) begin : g_fill
    assign fill_line_o[b*BUS_W +: BUS_W] =
      (beat_i && ptr_q == BEAT_W'(b)) ? beat_data_i : dw_q[b];
  end

  a_r4_slot_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> !vld_q[ptr_q]);
endmodule

// File: rtl/ifetch_line_cache.sv
module ifetch_line_cache
  import ilc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int BUS_W     = 64,
  parameter int LINE_W    = 256,
  parameter int NUM_LINES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_cacheable_i,
  output logic              fetch_valid_o,
  output logic [WORD_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  output logic              unc_req_o,
  output logic [ADDR_W-1:0] unc_addr_o,
  input  logic              unc_rvalid_i,
  input  logic [WORD_W-1:0] unc_rdata_i,
  input  logic              snoop_wr_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              flush_i
);
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int WOFF_W = $clog2(WORD_W / 8);
  localparam int DOFF_W = $clog2(BUS_W / 8);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int BEATS  = LINE_W / BUS_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int WPB    = BUS_W / WORD_W;
  localparam int HSEL_W = $clog2(WPB);

  // address fields
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  logic [LA_W-1:0]   f_line;
  logic [BEAT_W-1:0] f_beat;
  logic [WSEL_W-1:0] f_word;
  logic [HSEL_W-1:0] f_half;
  logic [IDX_W-1:0]  s_idx;
  logic [TAG_W-1:0]  s_tag;
  logic [LA_W-1:0]   s_line;
  logic              unused_snoop_off;

  assign f_idx  = fetch_addr_i[OFF_W +: IDX_W];
  assign f_tag  = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign f_line = fetch_addr_i[ADDR_W-1 -: LA_W];
  assign f_beat = fetch_addr_i[DOFF_W +: BEAT_W];
  assign f_word = fetch_addr_i[WOFF_W +: WSEL_W];
  assign f_half = fetch_addr_i[WOFF_W +: HSEL_W];
  assign s_idx  = snoop_addr_i[OFF_W +: IDX_W];
  assign s_tag  = snoop_addr_i[ADDR_W-1 -: TAG_W];
  assign s_line = snoop_addr_i[ADDR_W-1 -: LA_W];
  assign unused_snoop_off = ^snoop_addr_i[OFF_W-1:0];

  fill_state_e       state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              stale_q;

  logic              flushing, stall, cached_req, start;
  logic              cache_hit, buf_hit_raw, buf_hit, buf_last, beat_in;
  logic              stale_now, tag_inst;
  logic [LA_W-1:0]   buf_line;
  logic [BUS_W-1:0]  buf_dword;
  logic [LINE_W-1:0] fill_line, rd_line;
  logic [WORD_W-1:0] line_words [WPL];
  logic [WORD_W-1:0] dw_words [WPB];

  assign stall      = flush_i | flushing;
  assign cached_req = fetch_req_i & fetch_cacheable_i & ~stall;
  assign start      = (state_q == FILL_IDLE) & cached_req & ~cache_hit;
  assign beat_in    = (state_q == FILL_BEATS) & mem_rvalid_i;
  assign buf_hit    = buf_hit_raw & ~stale_q;
  assign stale_now  = stale_q | stall | (snoop_wr_i & (s_line == buf_line));
  assign tag_inst   = buf_last & ~stale_now;

  ilc_tag_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (f_idx),
    .rd_tag_i   (f_tag),
    .rd_hit_o   (cache_hit),
    .snoop_i    (snoop_wr_i),
    .snoop_idx_i(s_idx),
    .snoop_tag_i(s_tag),
    .inst_i     (tag_inst),
    .inst_idx_i (buf_line[IDX_W-1:0]),
    .inst_tag_i (buf_line[LA_W-1:IDX_W]),
    .flush_i    (flush_i),
    .flushing_o (flushing)
  );

  ilc_data_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_data (
    .clk_i    (clk_i),
    .wr_i     (tag_inst),
    .wr_idx_i (buf_line[IDX_W-1:0]),
    .wr_line_i(fill_line),
    .rd_idx_i (f_idx),
    .rd_line_o(rd_line)
  );

  ilc_line_buffer #(
    .LA_W(LA_W), .BUS_W(BUS_W), .BEATS(BEATS), .BEAT_W(BEAT_W), .LINE_W(LINE_W)
  ) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (state_q != FILL_IDLE),
    .start_i     (start),
    .start_line_i(f_line),
    .start_beat_i(f_beat),
    .beat_i      (beat_in),
    .beat_data_i (mem_rdata_i),
    .look_line_i (f_line),
    .look_beat_i (f_beat),
    .hit_o       (buf_hit_raw),
    .hit_dword_o (buf_dword),
    .line_o      (buf_line),
    .last_o      (buf_last),
    .fill_line_o (fill_line)
  );

  for (genvar w = 0; w < WPL; w++) begin : g_lw
    assign line_words[w] = rd_line[w*WORD_W +: WORD_W];
  end
  for (genvar h = 0; h < WPB; h++) begin : g_dw
    assign dw_words[h] = buf_dword[h*WORD_W +: WORD_W];
  end

  // refill sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FILL_IDLE;
      req_addr_q <= '0;
      stale_q    <= 1'b0;
    end else begin
      unique case (state_q)
        FILL_IDLE: if (start) begin
          state_q    <= FILL_REQ;
          req_addr_q <= {fetch_addr_i[ADDR_W-1:DOFF_W], {DOFF_W{1'b0}}};
          stale_q    <= 1'b0;
        end
        FILL_REQ:   if (mem_gnt_i) state_q <= FILL_BEATS;
        FILL_BEATS: if (buf_last)  state_q <= FILL_IDLE;
        default:    state_q <= FILL_IDLE;
      endcase
      if (state_q != FILL_IDLE && stale_now) stale_q <= 1'b1;
    end
  end

  assign mem_req_o  = (state_q == FILL_REQ);
  assign mem_addr_o = req_addr_q;
  assign unc_req_o  = fetch_req_i & ~fetch_cacheable_i;
  assign unc_addr_o = fetch_addr_i;

  always_comb begin
    if (!fetch_cacheable_i) begin
      fetch_valid_o = fetch_req_i & unc_rvalid_i;
      fetch_data_o  = unc_rdata_i;
    end else begin
      fetch_valid_o = cached_req & (cache_hit | buf_hit);
      fetch_data_o  = cache_hit ? line_words[f_word] : dw_words[f_half];
    end
  end

  a_r1_hit_zero_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && fetch_cacheable_i && !stall && cache_hit) |-> fetch_valid_o);

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r8_unc_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_cacheable_i) |-> unc_rvalid_i);

  a_r10_no_stale_install: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_q |-> !tag_inst);

  a_r11_stall_in_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |-> !(fetch_valid_o && fetch_cacheable_i));
endmodule

// File: tb/ifetch_line_cache_test.sv
`timescale 1ns/100ps
module ifetch_line_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_req = 1'b0, f_c = 1'b0;
  logic [31:0] f_addr = '0;
  logic        fetch_valid_o;
  logic [31:0] fetch_data_o;
  logic        mem_req_o, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_rdata = '0;
  logic        unc_req_o, unc_rvalid = 1'b0;
  logic [31:0] unc_addr_o, unc_rdata = '0;
  logic        snoop = 1'b0, flush = 1'b0;
  logic [31:0] snoop_addr = '0;

  always #2 clk = ~clk;

  ifetch_line_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(f_req), .fetch_addr_i(f_addr), .fetch_cacheable_i(f_c),
    .fetch_valid_o(fetch_valid_o), .fetch_data_o(fetch_data_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .unc_req_o(unc_req_o), .unc_addr_o(unc_addr_o),
    .unc_rvalid_i(unc_rvalid), .unc_rdata_i(unc_rdata),
    .snoop_wr_i(snoop), .snoop_addr_i(snoop_addr), .flush_i(flush)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int gap = 1, unc_lat = 2;
  int req_count = 0, unc_count = 0, beats_sent = 0, serve_beats = 0, viol = 0;
  bit mem_busy = 0;
  logic [31:0] last_req_addr = '0, last_unc_addr = '0, gen = 32'h100;

  localparam logic [20:0] TAG_A = 21'h0ABCD, TAG_B = 21'h1F00F, TAG_C = 21'h05555;
  bit          exp_vld [64];
  logic [20:0] exp_tag [64];
  logic [31:0] exp_gen [64];

  function automatic logic [31:0] memw(input logic [31:0] a, input logic [31:0] g);
    return (a * 32'h9E3779B1) ^ g ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] mk(input logic [20:0] t, input int idx, input int w);
    return {t, 6'(idx), 3'(w), 2'b00};
  endfunction

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic slot();
    @(negedge clk); #0.5;
  endtask

  // refill responder: grant, then four beats in wrap order
  initial begin
    forever begin
      slot();
      if (mem_req_o) begin
        req_count++;
        last_req_addr = mem_addr_o;
        mem_gnt = 1'b1; mem_busy = 1; beats_sent = 0;
        slot();
        mem_gnt = 1'b0;
        for (int k = 0; k < 4; k++) begin
          for (int g = 0; g < gap; g++) begin
            mem_rvalid = 1'b0;
            if (mem_req_o) viol++;
            slot();
          end
          begin
            logic [1:0]  b;
            logic [31:0] da;
            b  = 2'(last_req_addr[4:3] + 2'(k));
            da = {last_req_addr[31:5], b, 3'b000};
            mem_rdata  = {memw(da + 32'd4, gen), memw(da, gen)};
            mem_rvalid = 1'b1;
            beats_sent = k + 1;
          end
          if (mem_req_o) viol++;
          slot();
        end
        mem_rvalid = 1'b0;
        mem_busy = 0;
      end
    end
  end

  // uncached responder
  initial begin
    forever begin
      slot();
      if (unc_req_o) begin
        last_unc_addr = unc_addr_o;
        repeat (unc_lat) slot();
        unc_rdata  = memw(last_unc_addr, gen);
        unc_rvalid = 1'b1;
        unc_count++;
        slot();
        unc_rvalid = 1'b0;
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input bit c, output logic [31:0] d, output int w);
    @(negedge clk);
    f_req = 1'b1; f_addr = a; f_c = c; w = 0;
    #1;
    while (!fetch_valid_o && w < 3000) begin
      @(negedge clk); #1; w++;
    end
    d = fetch_data_o;
    serve_beats = beats_sent;
    @(negedge clk);
    f_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (mem_busy || mem_req_o) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic do_cached(input logic [31:0] a);
    int rc0, w;
    int idx;
    logic [31:0] d;
    bit hit;
    idx = int'(a[10:5]);
    rc0 = req_count;
    hit = exp_vld[idx] && exp_tag[idx] == a[31:11];
    fetch(a, 1'b1, d, w);
    if (hit) begin
      chk("R1 hit wait cycles", 32'(w), 32'd0);
      chk("R1 hit issues no request", 32'(req_count - rc0), 32'd0);
      chk("R2 hit word data", d, memw(a, exp_gen[idx]));
    end else begin
      chk("R3 one request per miss", 32'(req_count - rc0), 32'd1);
      chk("R3 request address", last_req_addr, {a[31:3], 3'b000});
      chk("R5 critical word with first beat", 32'(serve_beats), 32'd1);
      chk("R4 miss word data", d, memw(a, gen));
      exp_vld[idx] = 1; exp_tag[idx] = a[31:11]; exp_gen[idx] = gen;
    end
  endtask

  initial begin
    logic [31:0] d;
    int w, rc0, uc0;
    for (int i = 0; i < 64; i++) exp_vld[i] = 0;

    repeat (3) @(negedge clk);
    #1;
    chk("R12 valid low in reset", 32'(fetch_valid_o), 32'd0);
    chk("R12 mem_req low in reset", 32'(mem_req_o), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R12 unc_req idle", 32'(unc_req_o), 32'd0);
    chk("R12 mem_req idle", 32'(mem_req_o), 32'd0);

    // R2 R4 sweep: fill every line with all four start beats
    gap = 1;
    for (int i = 0; i < 64; i++) begin
      do_cached(mk(TAG_A, i, i % 8));
      wait_idle();
    end
    for (int i = 0; i < 64; i++)
      for (int wd = 0; wd < 8; wd++) do_cached(mk(TAG_A, i, wd));

    // R2 conflict on one index
    do_cached(mk(TAG_B, 5, 2)); wait_idle();
    chk("R2 displaced line invalid", 32'(exp_vld[5] && exp_tag[5] == TAG_A), 32'd0);
    do_cached(mk(TAG_A, 5, 2)); wait_idle();

    // R6 later word served from staging buffer
    gap = 3;
    do_cached(mk(TAG_C, 10, 0));
    rc0 = req_count;
    fetch(mk(TAG_C, 10, 7), 1'b1, d, w);
    chk("R6 no new request", 32'(req_count - rc0), 32'd0);
    chk("R6 served on its beat", 32'(serve_beats), 32'd4);
    chk("R6 data", d, memw(mk(TAG_C, 10, 7), gen));
    wait_idle();
    do_cached(mk(TAG_C, 10, 3));

    // R7 miss behind running refill
    viol = 0;
    do_cached(mk(TAG_C, 20, 0));
    do_cached(mk(TAG_C, 21, 5));
    wait_idle();
    chk("R7 no request while beats outstanding", 32'(viol), 32'd0);
    do_cached(mk(TAG_C, 20, 6));
    do_cached(mk(TAG_C, 21, 1));

    // R10 snoop of line under refill
    do_cached(mk(TAG_C, 30, 2));
    @(negedge clk); snoop = 1'b1; snoop_addr = mk(TAG_C, 30, 0);
    @(negedge clk); snoop = 1'b0;
    exp_vld[30] = 0;
    wait_idle();
    rc0 = req_count;
    do_cached(mk(TAG_C, 30, 5));
    chk("R10 snooped refill not installed", 32'(req_count - rc0), 32'd1);
    wait_idle();

    // R8 uncached bypass
    gap = 1;
    gen = gen + 32'h1;
    rc0 = req_count; uc0 = unc_count;
    fetch(mk(TAG_A, 0, 3), 1'b0, d, w);
    chk("R8 uncached data", d, memw(mk(TAG_A, 0, 3), gen));
    chk("R8 uncached address", last_unc_addr, mk(TAG_A, 0, 3));
    chk("R8 no refill request", 32'(req_count - rc0), 32'd0);
    chk("R8 one uncached access", 32'(unc_count - uc0), 32'd1);
    do_cached(mk(TAG_A, 0, 3));
    fetch(mk(TAG_B, 40, 1), 1'b0, d, w);
    chk("R8 uncached data 2", d, memw(mk(TAG_B, 40, 1), gen));
    rc0 = req_count;
    do_cached(mk(TAG_B, 40, 1));
    chk("R8 uncached fetch did not allocate", 32'(req_count - rc0), 32'd1);
    wait_idle();

    // R9 snoop invalidation
    @(negedge clk); snoop = 1'b1; snoop_addr = mk(TAG_A, 1, 4);
    @(negedge clk); snoop = 1'b0;
    exp_vld[1] = 0;
    do_cached(mk(TAG_A, 1, 0));
    wait_idle();
    @(negedge clk); snoop = 1'b1; snoop_addr = mk(TAG_B, 2, 0);
    @(negedge clk); snoop = 1'b0;
    rc0 = req_count;
    do_cached(mk(TAG_A, 2, 6));
    chk("R9 other-tag snoop ignored", 32'(req_count - rc0), 32'd0);

    // R11 global invalidate
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 64; i++) exp_vld[i] = 0;
    rc0 = req_count;
    fetch(mk(TAG_A, 3, 1), 1'b1, d, w);
    chk("R11 stalled during sweep", 32'(w >= 62), 32'd1);
    chk("R11 miss after flush", 32'(req_count - rc0), 32'd1);
    chk("R11 data after flush", d, memw(mk(TAG_A, 3, 1), gen));
    exp_vld[3] = 1; exp_tag[3] = TAG_A; exp_gen[3] = gen;
    wait_idle();
    for (int i = 0; i < 64; i++) begin
      if (i != 3) begin
        do_cached(mk(TAG_A, i, 7));
        wait_idle();
      end
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule